// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs Clause 22 management transactions towards an external PHY from one 32-bit management word. A host writes the packed word; the engine sends a 32-bit preamble of ones and then the 32 frame bits, MSB first, on a serial data line. It also generates the management clock, a division of the system clock chosen from a fixed set of ratios.

For a read (operation field 10) the engine releases the data line for the turnaround and data phases. It samples the PHY's reply on each rising clock edge and places the 16 bits in the low half of the same management word. An idle flag shows when no transfer is running; the host polls it before reading back the word. A port-enable input gates all activity, and removing it aborts a running transfer.

The controller has five states. IDLE goes to PREAMBLE on an accepted write. PREAMBLE goes to HEADER after 32 bits. HEADER goes to TURN after 14 bits. TURN goes to DATA after 2 bits. DATA returns to IDLE after 16 bits. Every state returns to IDLE as soon as port enable is low. Bits advance on the falling management-clock edge.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: During and right after reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `frame_q` is 0.
- R2: A `wr_en` pulse while `idle` is 1 and `port_en` is 1 stores `wr_data` in `frame_q` and starts a transfer. `idle` then reads 0 for exactly 64 MDC periods, during which `mdc` shows 64 rising edges.
- R3: The serial stream is 32 ones followed by `frame_q` bits 31 down to 0. Each bit is set up while `mdc` is low and held across the rising edge. The word layout is start [31:30] = 01, operation [29:28], PHY address [27:23], register address [22:18], turnaround [17:16] = 10, data [15:0].
- R4: `div_sel` picks the ratio of clock cycles per MDC period: 0→8, 1→16, 2→32, 3→48, 4→64, 5/6/7→96. With EXT_RATIOS=0, codes 3, 5, 6 and 7 give 64. MDC is high and low for half the ratio each. The code is latched at the start of a transfer.
- R5: When the operation field [29:28] is 10 (read), `mdio_oe` is 0 for the last 18 bits (turnaround and data). `mdio_i` is sampled on the rising MDC edge of each of the last 16 bits, MSB first. At the end, `frame_q[15:0]` holds the sampled value and `frame_q[31:16]` is unchanged.
- R6: For any other operation code (01 = write), `mdio_oe` is 1 for all 64 bits and `frame_q` keeps the written word after the transfer.
- R7: A `wr_en` pulse while a transfer is running is ignored. The stream, the timing and `frame_q` are unaffected.
- R8: While `port_en` is 0, `mdc` and `mdio_oe` stay 0, `idle` stays 1 and writes are ignored.
- R9: If `port_en` falls during a transfer, the next cycle shows `idle`=1, `mdc`=0 and `mdio_oe`=0. `frame_q` keeps the written word.
- R10: `mdc` is 0 whenever `idle` is 1. `idle` returns to 1 at the same edge as the final falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 3 | MDC ratio code |
| wr_en | input | 1 | Write strobe for the management word |
| wr_data | input | 32 | Management word to write |
| frame_q | output | 32 | Management word readback |
| idle | output | 1 | No transfer in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
Every cycle, the assertions check these properties:
- Each MDC half period matches the ratio latched at the start.
- Output enable never appears without port enable.
- A quiet line while idle.
- Only an accepted write or the end of a transfer may change the management word.
- A transfer begins only from an enabled write.
- A disabled port is idle on the next cycle.

The serial bit order, turnaround release, read-data capture and total transfer length can only be shown by the bench's PHY model. That model follows each rising MDC edge and compares against a stream built from the written word. The abort and busy-write scenarios are also directed in the bench.

// File: rtl/mdio_engine_pkg.sv
package mdio_engine_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

    localparam int FRAME_W  = 32;
    localparam int DATA_W   = 16;
    localparam int PRE_LEN  = 32;
    localparam int HEAD_LEN = 14;
    localparam int TURN_LEN = 2;
    localparam int CNT_W    = $clog2(PRE_LEN);
    localparam int HALF_W   = 6;
    localparam int OP_HI    = 29;
    localparam int OP_LO    = 28;
    localparam logic [1:0] OP_READ = 2'b10;

    // half of the MDC period in system clock cycles, per ratio code
    function automatic logic [HALF_W-1:0] half_period(input logic [2:0] code, input bit ext);
        logic [HALF_W-1:0] h;
        case (code)
            3'd0:    h = 6'd4;
            3'd1:    h = 6'd8;
            3'd2:    h = 6'd16;
            3'd3:    h = ext ? 6'd24 : 6'd32;
            3'd4:    h = 6'd32;
            default: h = ext ? 6'd48 : 6'd32;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise_tick,
    output logic              fall_tick
);
    logic [HALF_W-1:0] cnt;
    logic              toggle_now;

    always_comb begin
        toggle_now = run && (cnt == half - HALF_W'(1));
        rise_tick  = toggle_now && !mdc;
        fall_tick  = toggle_now && mdc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (toggle_now) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
    parameter int W     = 32,
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    input  logic             shift,
    input  logic             capture,
    input  logic             din,
    output logic             msb,
    output logic [CAP_W-1:0] cap
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cap  <= '0;
        end else begin
            if (load)
                sreg <= load_val;
            else if (shift)
                sreg <= {sreg[W-2:0], 1'b0};
            if (capture)
                cap <= {cap[CAP_W-2:0], din};
        end
    end

    assign msb = sreg[W-1];
endmodule

// File: rtl/mdio_ctrl_fsm.sv
module mdio_ctrl_fsm
    import mdio_engine_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_en,
    input  logic        start_req,
    input  logic        req_read,
    input  logic        rise_tick,
    input  logic        fall_tick,
    output mdio_state_e state,
    output logic        accept,
    output logic        finish,
    output logic        read_mode,
    output logic        shift_en,
    output logic        capture_en,
    output logic        drive_en,
    output logic        preamble
);
    mdio_state_e      state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             read_n;
    logic             last_bit;

    assign last_bit = fall_tick && (cnt == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            read_mode <= 1'b0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            read_mode <= read_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        read_n  = read_mode;
        if (!port_en) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start_req) begin
                    state_n = ST_PREAMBLE;
                    cnt_n   = CNT_W'(PRE_LEN - 1);
                    read_n  = req_read;
                end
                ST_PREAMBLE: if (last_bit) begin
                    state_n = ST_HEADER;
                    cnt_n   = CNT_W'(HEAD_LEN - 1);
                end else if (fall_tick) begin
                    cnt_n = cnt - CNT_W'(1);
                end
                ST_HEADER: if (last_bit) begin
                    state_n = ST_TURN;
                    cnt_n   = CNT_W'(TURN_LEN - 1);
                end else if (fall_tick) begin
                    cnt_n = cnt - CNT_W'(1);
                end
                ST_TURN: if (last_bit) begin
                    state_n = ST_DATA;
                    cnt_n   = CNT_W'(DATA_W - 1);
                end else if (fall_tick) begin
                    cnt_n = cnt - CNT_W'(1);
                end
                ST_DATA: if (last_bit) begin
                    state_n = ST_IDLE;
                end else if (fall_tick) begin
                    cnt_n = cnt - CNT_W'(1);
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        accept     = start_req && port_en && (state == ST_IDLE);
        finish     = port_en && (state == ST_DATA) && last_bit;
        shift_en   = fall_tick && (state == ST_HEADER || state == ST_TURN || state == ST_DATA);
        capture_en = rise_tick && read_mode && (state == ST_DATA);
        drive_en   = port_en && (state != ST_IDLE)
                     && !(read_mode && (state == ST_TURN || state == ST_DATA));
        preamble   = (state == ST_PREAMBLE);
    end
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_engine_pkg::*;
#(
    parameter bit EXT_RATIOS = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_en,
    input  logic [2:0]  div_sel,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] frame_q,
    output logic        idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_state_e       state;
    logic              accept, finish, read_mode, shift_en, capture_en, drive_en, preamble;
    logic              rise_tick, fall_tick, run, msb;
    logic [HALF_W-1:0] half_q;
    logic [DATA_W-1:0] cap;

    assign idle = (state == ST_IDLE);
    assign run  = !idle && port_en;

    mdio_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_en    (port_en),
        .start_req  (wr_en),
        .req_read   (wr_data[OP_HI:OP_LO] == OP_READ),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .state      (state),
        .accept     (accept),
        .finish     (finish),
        .read_mode  (read_mode),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .drive_en   (drive_en),
        .preamble   (preamble)
    );

    mdio_clkdiv #(.HALF_W(HALF_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .half      (half_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_shifter #(.W(FRAME_W), .CAP_W(DATA_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wr_data),
        .shift    (shift_en),
        .capture  (capture_en),
        .din      (mdio_i),
        .msb      (msb),
        .cap      (cap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            half_q  <= half_period(3'd0, EXT_RATIOS);
        end else if (accept) begin
            frame_q <= wr_data;
            half_q  <= half_period(div_sel, EXT_RATIOS);
        end else if (finish && read_mode) begin
            frame_q[DATA_W-1:0] <= cap;
        end
    end

    assign mdio_o  = preamble ? 1'b1 : msb;
    assign mdio_oe = drive_en;
endmodule

// File: rtl/mdio_engine_checker.sv
module mdio_engine_checker
    import mdio_engine_pkg::*;
#(
    parameter bit EXT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        port_en,
    input logic [2:0]  div_sel,
    input logic        wr_en,
    input logic [31:0] frame_q,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_oe
);
    logic [HALF_W-1:0] lat_half;
    logic [HALF_W:0]   gap;
    logic              mdc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_half <= half_period(3'd0, EXT);
            gap      <= '0;
            mdc_q    <= 1'b0;
        end else begin
            mdc_q <= mdc;
            if (wr_en && idle && port_en)
                lat_half <= half_period(div_sel, EXT);
            if (idle)
                gap <= '0;
            else if (mdc != mdc_q)
                gap <= (HALF_W+1)'(1);
            else
                gap <= gap + (HALF_W+1)'(1);
        end
    end

    assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && (mdc != mdc_q)) |-> (gap == {1'b0, lat_half}));

    assert_oe_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> port_en);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));

    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_q != $past(frame_q)) |-> ($past(wr_en && idle && port_en) || $rose(idle)));

    assert_start_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> $past(wr_en && port_en));

    assert_disable_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> idle);
endmodule

bind mdio_mgmt_engine mdio_engine_checker #(.EXT(EXT_RATIOS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_en (port_en),
    .div_sel (div_sel),
    .wr_en   (wr_en),
    .frame_q (frame_q),
    .idle    (idle),
    .mdc     (mdc),
    .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_mgmt_engine.sv
module sim_mdio_mgmt_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] frame_q;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mdio_mgmt_engine u0 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
        .wr_en(wr_en), .wr_data(wr_data), .frame_q(frame_q), .idle(idle),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [2:0] code);
        case (code)
            3'd0: return 8;
            3'd1: return 16;
            3'd2: return 32;
            3'd3: return 48;
            3'd4: return 64;
            default: return 96;
        endcase
    endfunction

    function automatic logic [31:0] make_word(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] regn, input logic [15:0] d);
        return {2'b01, (rd ? 2'b10 : 2'b01), phy, regn, 2'b10, d};
    endfunction

    function automatic logic exp_bit(input logic [31:0] w, input int k);
        return (k < 32) ? 1'b1 : w[63-k];
    endfunction

    task automatic run_xfer(input logic [31:0] word, input logic [2:0] sel,
                            input logic [15:0] rd_val, input bit poke);
        int  h = ratio_of(sel) / 2;
        bit  rd = (word[29:28] == 2'b10);
        int  busy = 0, rises = 0, last_rise = 0;
        int  bad_bit = 0, bad_oe = 0, bad_per = 0;
        bit  prev = 1'b0;
        logic [31:0] exp_q;
        mdio_i = 1'b1;
        @(negedge clk);
        wr_data = word; div_sel = sel; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; div_sel = ~sel;
        while (!idle && busy < 20000) begin
            busy++;
            if (wr_en) wr_en = 1'b0;
            if (mdc && !prev) begin
                if (rises < 64) begin
                    if (mdio_oe !== !(rd && rises >= 46)) bad_oe++;
                    if (mdio_oe && mdio_o !== exp_bit(word, rises)) bad_bit++;
                end
                if (rises > 0 && (busy - last_rise) != 2*h) bad_per++;
                last_rise = busy;
                rises++;
                mdio_i = (rises >= 48 && rises < 64) ? rd_val[63-rises] : 1'b1;
                if (poke && rises == 10) begin
                    wr_en = 1'b1; wr_data = ~word;
                end
            end
            prev = mdc;
            @(negedge clk);
        end
        exp_q = rd ? {word[31:16], rd_val} : word;
        chk(busy == 128*h, "R2 busy duration", busy, 128*h);
        chk(rises == 64, "R2 mdc rising edges", rises, 64);
        chk(bad_bit == 0, "R3 serial stream mismatches", bad_bit, 0);
        chk(bad_per == 0, "R4 mdc period mismatches", bad_per, 0);
        chk(bad_oe == 0, rd ? "R5 read oe release" : "R6 write oe held", bad_oe, 0);
        chk(frame_q == exp_q, rd ? "R5 read data in word" : "R6 word kept", frame_q, exp_q);
        chk(mdc == 1'b0, "R10 mdc low at end", mdc, 0);
        if (poke)
            chk(frame_q[31:16] == word[31:16], "R7 busy write ignored", frame_q, exp_q);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        bit          quiet;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset outputs",
            {idle, mdc, mdio_oe}, 3'b100);
        chk(frame_q == 32'h0, "R1 reset word", frame_q, 0);
        rst_n = 1'b1; port_en = 1'b1;
        @(negedge clk);
        chk(idle == 1'b1 && mdc == 1'b0, "R1 after reset", {idle, mdc}, 2'b10);

        // directed corners: fastest and slowest ratios, all-ones and all-zero reads
        run_xfer(make_word(1'b0, 5'd1, 5'd0, 16'hA5C3), 3'd0, 16'h0, 1'b0);
        run_xfer(make_word(1'b1, 5'd31, 5'd31, 16'h0), 3'd0, 16'hFFFF, 1'b0);
        run_xfer(make_word(1'b1, 5'd0, 5'd2, 16'h1234), 3'd7, 16'h0000, 1'b1);
        run_xfer(make_word(1'b0, 5'd7, 5'd4, 16'hFFFF), 3'd3, 16'h0, 1'b1);

        // R9: abort by dropping port enable
        w = make_word(1'b1, 5'd3, 5'd1, 16'hBEEF);
        @(negedge clk);
        wr_data = w; div_sel = 3'd1; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (300) @(negedge clk);
        chk(idle == 1'b0, "R9 busy before abort", idle, 0);
        port_en = 1'b0;
        @(negedge clk);
        chk(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0, "R9 abort outputs",
            {idle, mdc, mdio_oe}, 3'b100);
        chk(frame_q == w, "R9 word kept after abort", frame_q, w);

        // R8: disabled port ignores writes
        wr_data = 32'h5A5A_1234; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        quiet = 1'b1;
        repeat (40) begin
            if (mdc || mdio_oe || !idle) quiet = 1'b0;
            @(negedge clk);
        end
        chk(quiet, "R8 quiet while disabled", quiet, 1);
        chk(frame_q == w, "R8 write ignored while disabled", frame_q, w);
        port_en = 1'b1;
        @(negedge clk);

        // random transfers
        for (int i = 0; i < 14; i++) begin
            logic [2:0] s = 3'($urandom_range(0, 7));
            bit r = 1'($urandom_range(0, 1));
            w = make_word(r, 5'($urandom), 5'($urandom), 16'($urandom));
            run_xfer(w, s, 16'($urandom), (i % 4) == 1);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule